// File: doc/BRIEF.md
# I2C Target Front End for an 8K-Byte Serial Memory

This block is a target on a two-wire I2C bus. It sits in front of an 8192-byte array, which is modelled here as a synchronous RAM inside the design. SCL and SDA are sampled with the system clock and filtered before any edge is decoded. The block finds START, repeated START and STOP conditions and checks the target address. It then loads a 13-bit location pointer from two address bytes and carries out writes or reads. The pointer steps after every byte and wraps across the whole array.

A master can write one byte or a run of any length. It can read from the current pointer, or it can load the pointer and then issue a repeated START and read. Reads keep streaming while the master acknowledges. A write-protect input blocks every change to the array, but the bus transaction still completes as normal. The block also recognises the entry code for high-speed mode, does not acknowledge it, and reports the mode until the next STOP. SDA is driven only through an open-drain enable: a high enable pulls the line low.

Top module: `i2c_mem_target`

## Requirements
- R1: The first byte after START is acknowledged only if bits 7..4 are 1010 and bits 3..1 equal `dev_sel_i`. Bit 0 selects the direction: 0 means write, 1 means read. Any other byte is not acknowledged, and the block then leaves SDA released until the next START or STOP.
- R2: After a matching write-direction address, two address bytes follow and each is acknowledged. Bits 4..0 of the first byte become pointer bits 12..8, and its bits 7..5 are ignored. The second byte becomes pointer bits 7..0.
- R3: Every data byte that follows the address bytes is acknowledged and stored at the pointer, and the pointer then steps by one. After location 8191 the pointer moves to location 0, so a long run overwrites the start of the array.
- R4: A read-direction address with no address bytes before it returns data starting at the pointer. The pointer holds one past the last location that was written or read.
- R5: Address bytes, then a repeated START with a read-direction address, return the data at the loaded location.
- R6: While the master acknowledges a read byte, the next location is sent, and the pointer wraps from 8191 to 0. After a non-acknowledge, SDA is released and the block waits for START or STOP.
- R7: While `wp_i` is high, data bytes are still acknowledged and the pointer still steps, but no location changes.
- R8: A first byte of the form 00001xxx is not acknowledged and sets `hs_mode_o`. `hs_mode_o` stays high across repeated STARTs and clears on STOP.
- R9: `sda_oe_o` changes only while SCL is low. It is low whenever the block is idle or ignoring the bus.
- R10: A pulse on SDA lasting one system clock while SCL is high is neither a START nor a STOP, and it does not corrupt the byte in flight.
- R11: After reset, `sda_oe_o` and `hs_mode_o` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| dev_sel_i | input | 3 | Target select bits compared with address bits 3..1 |
| wp_i | input | 1 | High blocks every change to the array |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| hs_mode_o | output | 1 | High-speed mode entered, held until STOP |

## Verification
Two events can fall on the same system-clock cycle: the array write of the final byte at location 8191, and the pointer wrapping to location 0. The bench writes a run that starts at 8190, so that one SCL falling edge both stores the byte at the top location and moves the pointer to 0. This is judged by a current-address read, which must return the earlier contents of location 0. A sequential read across the boundary must then return both new bytes. A second overlap pairs write protection with acknowledgement. A protected run must still acknowledge every byte and still move the pointer, and this is shown by reading from the pointer afterwards while the array contents stay unchanged.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_MACK, PH_WAIT} phase_e;
  typedef enum logic [1:0] {K_DEV, K_WHI, K_WLO, K_DATA} kind_e;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam logic [4:0] HS_CODE  = 5'b00001;
endpackage

// File: rtl/i2cm_filter.sv
`timescale 1ns/1ps
module i2cm_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1_q, s2_q, filt_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          filt_d;

  always_comb begin
    cnt_d  = cnt_q;
    filt_d = filt_q;
    if (s2_q == filt_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      filt_d = s2_q;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      s1_q   <= raw_i;
      s2_q   <= s1_q;
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign filt_o = filt_q;

  // The filtered line only moves after the synchronised input has disagreed with it
  assert_filter_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> $past(s2_q != filt_q));
endmodule

// File: rtl/i2cm_ram.sv
`timescale 1ns/1ps
module i2cm_ram #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_mem_target.sv
`timescale 1ns/1ps
module i2c_mem_target
  import i2cm_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel_i,
  input  logic       wp_i,
  output logic       sda_oe_o,
  output logic       hs_mode_o
);
  localparam int HI_W = ADDR_W - 8;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_ff;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_s = rst_ff[1];

  // line conditioning, one filter per bus line
  logic [1:0] line_raw, line_f;
  assign line_raw = {sda_i, scl_i};
  for (genvar g = 0; g < 2; g++) begin : g_line
    i2cm_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_s), .raw_i(line_raw[g]), .filt_o(line_f[g]));
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = line_f[0];
  assign sda_f = line_f[1];

  logic start_det, stop_det, scl_rise, scl_fall;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;

  phase_e             phase_q, phase_d;
  kind_e              kind_q, kind_d;
  logic [3:0]         cnt_q, cnt_d;
  logic [7:0]         sh_q, sh_d, tx_q, tx_d;
  logic [ADDR_W-1:0]  ptr_q, ptr_d;
  logic               rw_q, rw_d, oe_q, oe_d, hs_q, hs_d, more_q, more_d;
  logic               ram_we;
  logic [7:0]         rdata;

  i2cm_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ptr_q), .wdata(sh_q),
    .raddr(ptr_q), .rdata(rdata));

  always_comb begin
    phase_d = phase_q; kind_d = kind_q; cnt_d = cnt_q; sh_d = sh_q;
    tx_d = tx_q; ptr_d = ptr_q; rw_d = rw_q; oe_d = oe_q;
    hs_d = hs_q; more_d = more_q; ram_we = 1'b0;
    if (stop_det) begin
      phase_d = PH_IDLE; oe_d = 1'b0; hs_d = 1'b0;
    end else if (start_det) begin
      phase_d = PH_RX; kind_d = K_DEV; cnt_d = '0; oe_d = 1'b0;
    end else begin
      unique case (phase_q)
        PH_RX: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_d  = {sh_q[6:0], sda_f};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_d = '0;
            unique case (kind_q)
              K_DEV: begin
                if (sh_q[7:4] == DEV_TYPE && sh_q[3:1] == dev_sel_i) begin
                  rw_d = sh_q[0]; oe_d = 1'b1; phase_d = PH_ACK;
                end else begin
                  if (sh_q[7:3] == HS_CODE) hs_d = 1'b1;
                  phase_d = PH_WAIT;
                end
              end
              K_WHI: begin
                ptr_d[ADDR_W-1:8] = sh_q[HI_W-1:0]; oe_d = 1'b1; phase_d = PH_ACK;
              end
              K_WLO: begin
                ptr_d[7:0] = sh_q; oe_d = 1'b1; phase_d = PH_ACK;
              end
              default: begin
                ram_we = ~wp_i; ptr_d = ptr_q + 1'b1; oe_d = 1'b1; phase_d = PH_ACK;
              end
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            if (kind_q == K_DEV && rw_q) begin
              tx_d = rdata; oe_d = ~rdata[7]; ptr_d = ptr_q + 1'b1;
              cnt_d = '0; phase_d = PH_TX;
            end else begin
              oe_d = 1'b0; phase_d = PH_RX;
              unique case (kind_q)
                K_DEV:   kind_d = K_WHI;
                K_WHI:   kind_d = K_WLO;
                default: kind_d = K_DATA;
              endcase
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_d = 1'b0; phase_d = PH_MACK;
            end else begin
              tx_d = {tx_q[6:0], 1'b0}; oe_d = ~tx_q[6]; cnt_d = cnt_q + 4'd1;
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) begin
            more_d = ~sda_f;
          end else if (scl_fall) begin
            if (more_q) begin
              tx_d = rdata; oe_d = ~rdata[7]; ptr_d = ptr_q + 1'b1;
              cnt_d = '0; phase_d = PH_TX;
            end else begin
              phase_d = PH_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      scl_q <= 1'b1; sda_q <= 1'b1;
      phase_q <= PH_IDLE; kind_q <= K_DEV; cnt_q <= '0; sh_q <= '0; tx_q <= '0;
      ptr_q <= '0; rw_q <= 1'b0; oe_q <= 1'b0; hs_q <= 1'b0; more_q <= 1'b0;
    end else begin
      scl_q <= scl_f; sda_q <= sda_f;
      phase_q <= phase_d; kind_q <= kind_d; cnt_q <= cnt_d; sh_q <= sh_d; tx_q <= tx_d;
      ptr_q <= ptr_d; rw_q <= rw_d; oe_q <= oe_d; hs_q <= hs_d; more_q <= more_d;
    end
  end

  assign sda_oe_o  = oe_q;
  assign hs_mode_o = hs_q;

  assert_release_ignore_R1: assert property (@(posedge clk) disable iff (!rst_s)
    (phase_q == PH_WAIT || phase_q == PH_IDLE) |-> !oe_q);
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_s)
    ram_we |=> (ptr_q == $past(ptr_q) + 1'b1));
  assert_hs_clear_R8: assert property (@(posedge clk) disable iff (!rst_s)
    stop_det |=> !hs_q);
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (!$stable(oe_q) && !$past(start_det || stop_det)) |-> !$past(scl_f));
endmodule

// File: tb/tb_i2c_mem_target.sv
`timescale 1ns/1ps
module tb_i2c_mem_target;
  localparam int Q = 16;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, hs_mode, sda_line;
  int n_chk = 0, n_err = 0, n_r9 = 0;
  logic done = 1'b0;

  logic [7:0]  m_mem [8192];
  bit          m_vld [8192];
  logic [12:0] m_ptr = '0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_mem_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .dev_sel_i(SEL), .wp_i(wp), .sda_oe_o(sda_oe), .hs_mode_o(hs_mode));

  // R9 monitor: the data output may not move while SCL is high
  logic scl_p = 1'b1, oe_p = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_p && (sda_oe !== oe_p)) n_r9++;
    scl_p <= scl_m; oe_p <= sda_oe;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bitx(input logic b, input logic glitch, output logic r);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(Q/2);
    if (glitch) begin sda_m = ~b; wq(1); sda_m = b; wq(Q/2 - 1); end
    else wq(Q/2);
    r = sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, input logic glitch, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bitx(b[i], glitch && i == 4, r);
    bitx(1'b1, 1'b0, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin bitx(1'b1, 1'b0, r); b[i] = r; end
    bitx(~mack, 1'b0, r);
  endtask

  function automatic logic [7:0] devb(input logic rd);
    return {4'b1010, SEL, rd};
  endfunction

  task automatic addr_phase(input logic [12:0] a);
    logic ack;
    wr_byte(devb(1'b0), 1'b0, ack); check("R1 dev ack", ack, 1'b1);
    wr_byte({3'($urandom), a[12:8]}, 1'b0, ack); check("R2 hi ack", ack, 1'b1);
    wr_byte(a[7:0], 1'b0, ack); check("R2 lo ack", ack, 1'b1);
  endtask

  task automatic do_write(input logic [12:0] a, input int n, input logic prot, input logic glitch);
    logic ack; logic [7:0] d;
    wp = prot;
    i2c_start(); addr_phase(a);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      wr_byte(d, glitch, ack);
      check(prot ? "R7 protected ack" : "R3 data ack", ack, 1'b1);
      if (!prot) begin m_mem[a] = d; m_vld[a] = 1'b1; end
      a = a + 13'd1;
    end
    i2c_stop(); wp = 1'b0; m_ptr = a;
  endtask

  task automatic read_run(input int n, input string tag);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      rd_byte(k != n - 1, b);
      if (m_vld[m_ptr]) check(tag, b, m_mem[m_ptr]);
      m_ptr = m_ptr + 13'd1;
    end
    wq(4);
    check("R6 released after nack", sda_oe, 1'b0);
    i2c_stop();
  endtask

  task automatic do_rread(input logic [12:0] a, input int n);
    logic ack;
    i2c_start(); addr_phase(a);
    i2c_start(); wr_byte(devb(1'b1), 1'b0, ack); check("R5 read ack", ack, 1'b1);
    m_ptr = a;
    read_run(n, n > 1 ? "R6 sequential data" : "R5 random data");
  endtask

  task automatic do_cread(input int n);
    logic ack;
    i2c_start(); wr_byte(devb(1'b1), 1'b0, ack); check("R4 read ack", ack, 1'b1);
    read_run(n, "R4 current data");
  endtask

  initial begin
    logic ack; logic [7:0] b;
    void'($urandom(32'd7301));
    wq(5); rst_n = 1'b1; wq(5);
    check("R11 oe after reset", sda_oe, 1'b0);
    check("R11 hs after reset", hs_mode, 1'b0);

    do_write(13'h0123, 4, 1'b0, 1'b0);
    do_rread(13'h0123, 4);
    do_write(13'h0040, 3, 1'b0, 1'b0);
    do_rread(13'h0040, 1);
    do_cread(2);

    // wrap: write at the top collides with the pointer wrap
    do_write(13'h0000, 1, 1'b0, 1'b0);
    do_write(13'h1FFE, 2, 1'b0, 1'b0);
    check("R3 pointer wrapped", m_ptr, 13'h0000);
    do_cread(1);
    do_write(13'h1FFF, 2, 1'b0, 1'b0);
    do_rread(13'h1FFE, 3);

    // protected write: acks, pointer moves, contents stay
    do_write(13'h0123, 3, 1'b1, 1'b0);
    do_cread(1);
    do_rread(13'h0123, 3);

    // mismatched address and wrong type byte are ignored
    i2c_start(); wr_byte({4'b1010, SEL ^ 3'b010, 1'b0}, 1'b0, ack);
    check("R1 mismatch nack", ack, 1'b0);
    wr_byte(8'h00, 1'b0, ack); check("R1 ignored byte nack", ack, 1'b0);
    check("R1 oe released", sda_oe, 1'b0);
    i2c_stop();
    i2c_start(); wr_byte({4'b1011, SEL, 1'b0}, 1'b0, ack);
    check("R1 wrong type nack", ack, 1'b0);
    i2c_stop();
    do_rread(13'h0123, 1);

    // high-speed entry code
    i2c_start(); wr_byte(8'h0D, 1'b0, ack);
    check("R8 hs code nack", ack, 1'b0);
    check("R8 hs set", hs_mode, 1'b1);
    i2c_start(); wr_byte(devb(1'b1), 1'b0, ack);
    check("R8 read after hs ack", ack, 1'b1);
    rd_byte(1'b0, b);
    if (m_vld[m_ptr]) check("R8 data in hs", b, m_mem[m_ptr]);
    m_ptr = m_ptr + 13'd1;
    check("R8 hs held over restart", hs_mode, 1'b1);
    i2c_stop(); wq(4);
    check("R8 hs cleared by stop", hs_mode, 1'b0);

    // glitch on SDA during SCL high
    do_write(13'h0200, 2, 1'b0, 1'b1);
    do_rread(13'h0200, 2);

    // constrained random runs
    for (int it = 0; it < 10; it++) begin
      logic [12:0] a; int n; logic pr;
      a = 13'($urandom); n = 1 + int'($urandom % 4); pr = ($urandom % 4) == 0;
      do_write(a, n, pr, 1'b0);
      if (pr) do_cread(1);
      do_rread(a, n);
    end

    check("R9 oe stable while SCL high", n_r9, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule